// File: doc/BRIEF.md
# I2C Byte Receive Interlock with Clock Stretching

This block sits between the bit level of an I2C controller and the software that reads received bytes. It takes SCL and SDA samples that are already filtered and synchronized, gathers eight data bits per byte, and moves each finished byte into a receive data register. At the same moment it sets a "byte ready" flag. Software reads the register and then clears the flag. If another byte finishes while the flag is still set, nothing is overwritten. The new byte is parked in a shadow register and the block pulls SCL low. The bus stays stalled until software clears the flag. The parked byte then moves into the data register, the flag is set again, and SCL is let go.

Two copies of the receive path run side by side, one for the master role and one for the slave role. Each has its own flag, and the two flags are merged onto a single interrupt output. START and STOP detection and the software clear requests arrive as single-cycle strobes. All state advances only on cycles where the external clock-enable `tick` is high.

Each path runs a three-state machine:
- `RX_IDLE`: not taking part in a transfer. It moves to `RX_RECV` on a START strobe.
- `RX_RECV`: shifting bits. It moves to `RX_HOLD` when a byte finishes while the flag is set and no clear arrives in the same tick. It moves to `RX_IDLE` on STOP. START keeps it in `RX_RECV` and restarts the count.
- `RX_HOLD`: SCL is driven low. It moves to `RX_RECV` on a clear, which loads the parked byte. It also moves to `RX_RECV` on START, which drops the parked byte. It moves to `RX_IDLE` on STOP, which also drops the parked byte.

Top module: `i2c_rx_interlock`

## Requirements
- R1: When `tick` is low, no output changes and no strobe (start, stop or clear) is taken.
- R2: In `RX_RECV`, each rising SCL edge shifts SDA in MSB first. The 8th rising edge after START, or after the previous acknowledge clock, completes a byte. The 9th rising edge is the acknowledge clock and is not shifted.
- R3: When a byte completes while that path's flag is 0, the byte appears on its `*_rdata` and the flag reads 1 on the next clock.
- R4: A clear strobe taken while not in `RX_HOLD` sets the flag to 0 and leaves `*_rdata` unchanged.
- R5: When a byte completes while the flag is 1 and no clear arrives in that tick, `*_rdata` and the flag keep their values and `scl_hold` reads 1 from the next clock.
- R6: A clear taken in `RX_HOLD` loads the parked byte into `*_rdata`, keeps the flag at 1, and drops `scl_hold` on the next clock.
- R7: A clear that arrives in the same tick as a byte completion is applied first. The new byte loads, the flag stays 1, and SCL is not held.
- R8: STOP (which takes priority over START) returns the path to `RX_IDLE`. It releases `scl_hold`, zeroes the bit count and drops any parked byte, but keeps the flag. Rising edges are ignored in `RX_IDLE`. START zeroes the bit count and discards a partial byte.
- R9: The master and slave paths work independently. `irq` is 1 while either flag is 1, and `scl_hold` is 1 while either path is in `RX_HOLD`.
- R10: After `rst_n` is asserted low, both data registers read 0, both flags read 0, and `scl_hold` and `irq` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Internal clock enable; logic advances only when high |
| scl_in | input | 1 | Filtered, synchronized SCL level |
| sda_in | input | 1 | Filtered, synchronized SDA level |
| mst_start | input | 1 | START strobe for the master path |
| mst_stop | input | 1 | STOP strobe for the master path |
| mst_clr | input | 1 | Software clear of the master flag |
| slv_start | input | 1 | START strobe for the slave path |
| slv_stop | input | 1 | STOP strobe for the slave path |
| slv_clr | input | 1 | Software clear of the slave flag |
| mst_rdata | output | DATA_W | Master receive data register |
| mst_full | output | 1 | Master byte-ready flag |
| slv_rdata | output | DATA_W | Slave receive data register |
| slv_full | output | 1 | Slave byte-ready flag |
| scl_hold | output | 1 | Open-drain request: 1 means drive SCL low |
| irq | output | 1 | Merged interrupt |

## Verification
The risky coincidence is a software clear landing in the same enable tick as the 8th rising SCL edge of the next byte. The clear must win, so the fresh byte goes straight into the register without a stall. The bench provokes this by raising the clear strobe in exactly the cycle its SCL edge is sampled. It then expects the new byte in the data register, the flag still at 1 and `scl_hold` at 0. A second coincidence is STOP arriving while a path is stalled. Here the bench expects SCL to be released, the old byte and flag to stay, and a later clear to leave the register untouched.

// File: rtl/rxi_pkg.sv
package rxi_pkg;

    localparam int NPATH = 2;   // index 0 = master, 1 = slave

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_RECV = 2'd1,
        RX_HOLD = 2'd2
    } rx_state_e;

endpackage

// File: rtl/rxi_scl_edge.sv
module rxi_scl_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic scl,
    output logic rise
);

    logic scl_q;

    // previous SCL level, sampled only on enable ticks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
        end else if (tick) begin
            scl_q <= scl;
        end
    end

    assign rise = scl & ~scl_q;

endmodule

// File: rtl/rxi_path.sv
module rxi_path
    import rxi_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              scl_rise,
    input  logic              sda,
    input  logic              start_s,
    input  logic              stop_s,
    input  logic              clr_s,
    output logic [DATA_W-1:0] rdata,
    output logic              full,
    output logic              hold
);

    localparam int              CNT_W    = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(DATA_W);

    rx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] shift_q, shadow_q;
    logic [DATA_W-1:0] byte_w;
    logic              start_ev, stop_ev, clr_ev, edge_ok, byte_done, hold_clr;

    assign start_ev  = tick & start_s;
    assign stop_ev   = tick & stop_s;
    assign clr_ev    = tick & clr_s;
    assign edge_ok   = tick & scl_rise & (state_q == RX_RECV) & ~start_s & ~stop_s;
    assign byte_done = edge_ok & (cnt_q == LAST_BIT);
    assign byte_w    = {shift_q[DATA_W-2:0], sda};
    assign hold_clr  = (state_q == RX_HOLD) & clr_ev & ~start_ev & ~stop_ev;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: begin
                if (start_ev && !stop_ev) state_d = RX_RECV;
            end
            RX_RECV: begin
                if (stop_ev)                            state_d = RX_IDLE;
                else if (start_ev)                      state_d = RX_RECV;
                else if (byte_done && full && !clr_ev)  state_d = RX_HOLD;
            end
            RX_HOLD: begin
                if (stop_ev)                   state_d = RX_IDLE;
                else if (start_ev || clr_ev)   state_d = RX_RECV;
            end
            default: state_d = RX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        hold = (state_q == RX_HOLD);
    end

    // bit counter, shifter, data and flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            shift_q  <= '0;
            shadow_q <= '0;
            rdata    <= '0;
            full     <= 1'b0;
        end else if (tick) begin
            if (start_ev || stop_ev) begin
                cnt_q <= '0;
            end else if (edge_ok) begin
                cnt_q <= (cnt_q == ACK_BIT) ? '0 : cnt_q + CNT_W'(1);
                if (cnt_q != ACK_BIT) shift_q <= byte_w;
            end

            if (hold_clr) begin
                rdata <= shadow_q;
                full  <= 1'b1;
            end else if (byte_done && (!full || clr_ev)) begin
                rdata <= byte_w;
                full  <= 1'b1;
            end else if (byte_done) begin
                shadow_q <= byte_w;
            end else if (clr_ev) begin
                full <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/i2c_rx_interlock.sv
module i2c_rx_interlock
    import rxi_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              mst_start,
    input  logic              mst_stop,
    input  logic              mst_clr,
    input  logic              slv_start,
    input  logic              slv_stop,
    input  logic              slv_clr,
    output logic [DATA_W-1:0] mst_rdata,
    output logic              mst_full,
    output logic [DATA_W-1:0] slv_rdata,
    output logic              slv_full,
    output logic              scl_hold,
    output logic              irq
);

    logic              scl_rise;
    logic [NPATH-1:0]  start_v, stop_v, clr_v, full_v, hold_v;
    logic [DATA_W-1:0] rdata_a [NPATH];

    assign start_v = {slv_start, mst_start};
    assign stop_v  = {slv_stop,  mst_stop};
    assign clr_v   = {slv_clr,   mst_clr};

    rxi_scl_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .scl   (scl_in),
        .rise  (scl_rise)
    );

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        rxi_path #(.DATA_W(DATA_W)) u_path (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .scl_rise (scl_rise),
            .sda      (sda_in),
            .start_s  (start_v[p]),
            .stop_s   (stop_v[p]),
            .clr_s    (clr_v[p]),
            .rdata    (rdata_a[p]),
            .full     (full_v[p]),
            .hold     (hold_v[p])
        );
    end

    assign mst_rdata = rdata_a[0];
    assign slv_rdata = rdata_a[1];
    assign mst_full  = full_v[0];
    assign slv_full  = full_v[1];
    assign scl_hold  = |hold_v;
    assign irq       = |full_v;

endmodule

// File: rtl/i2c_rx_interlock_chk.sv
module i2c_rx_interlock_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              mst_stop,
    input logic              mst_clr,
    input logic              slv_stop,
    input logic              slv_clr,
    input logic [DATA_W-1:0] mst_rdata,
    input logic              mst_full,
    input logic [DATA_W-1:0] slv_rdata,
    input logic              slv_full,
    input logic              scl_hold,
    input logic              irq
);

    AST_IDLE_TICK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(mst_rdata) && $stable(slv_rdata) && $stable(mst_full)
                   && $stable(slv_full) && $stable(scl_hold)));                    // R1

    AST_MST_DATA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_full && !(tick && mst_clr)) |=> $stable(mst_rdata));                 // R5

    AST_SLV_DATA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_full && !(tick && slv_clr)) |=> $stable(slv_rdata));                 // R5

    AST_HOLD_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hold |-> (mst_full || slv_full));                                     // R9

    AST_HOLD_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hold |-> irq);                                                        // R9

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mst_stop && slv_stop) |=> !scl_hold);                            // R8

    AST_STOP_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mst_stop && mst_full && !mst_clr) |=> mst_full);                 // R8

    AST_FLAG_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mst_full) |-> $past(tick));                                         // R3

endmodule

bind i2c_rx_interlock i2c_rx_interlock_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_i2c_rx_interlock.sv
`timescale 1ns/100ps
module test_i2c_rx_interlock;

    localparam int DW = 8;
    localparam logic [7:0] VEC [0:5] = '{8'hA5, 8'h00, 8'hFF, 8'h3C, 8'h81, 8'h5A};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic scl_drv = 1'b0;
    logic sda = 1'b1;
    logic mst_start = 0, mst_stop = 0, mst_clr = 0;
    logic slv_start = 0, slv_stop = 0, slv_clr = 0;
    logic [DW-1:0] mst_rdata, slv_rdata;
    logic mst_full, slv_full, scl_hold, irq;
    logic scl_in;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    // open-drain bus: either side can pull SCL low
    assign scl_in = scl_drv & ~scl_hold;

    always #2.5 clk = ~clk;

    i2c_rx_interlock #(.DATA_W(DW)) i_i2c_rx_interlock (
        .clk(clk), .rst_n(rst_n), .tick(tick), .scl_in(scl_in), .sda_in(sda),
        .mst_start(mst_start), .mst_stop(mst_stop), .mst_clr(mst_clr),
        .slv_start(slv_start), .slv_stop(slv_stop), .slv_clr(slv_clr),
        .mst_rdata(mst_rdata), .mst_full(mst_full),
        .slv_rdata(slv_rdata), .slv_full(slv_full),
        .scl_hold(scl_hold), .irq(irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // one SCL bit; optional master clear in the cycle the rising edge is sampled
    task automatic send_bit(input logic b, input logic with_clr);
        @(negedge clk); scl_drv = 1'b0; sda = b;
        @(negedge clk); scl_drv = 1'b1; mst_clr = with_clr;
        @(negedge clk); scl_drv = 1'b0; mst_clr = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = DW - 1; i >= 0; i--) send_bit(v[i], 1'b0);
    endtask

    // 0 mst_start, 1 mst_stop, 2 mst_clr, 3 slv_start, 4 slv_stop, 5 slv_clr
    task automatic strobe(input int which);
        @(negedge clk);
        case (which)
            0: mst_start = 1; 1: mst_stop = 1; 2: mst_clr = 1;
            3: slv_start = 1; 4: slv_stop = 1; default: slv_clr = 1;
        endcase
        @(negedge clk);
        mst_start = 0; mst_stop = 0; mst_clr = 0;
        slv_start = 0; slv_stop = 0; slv_clr = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 mst_full", mst_full, 0);
        chk("R10 slv_full", slv_full, 0);
        chk("R10 mst_rdata", mst_rdata, 0);
        chk("R10 slv_rdata", slv_rdata, 0);
        chk("R10 scl_hold", scl_hold, 0);
        chk("R10 irq", irq, 0);

        // table walk: R2 R3 R4 R9
        strobe(0);
        for (int k = 0; k < 6; k++) begin
            send_byte(VEC[k]);
            chk("R3 mst_full", mst_full, 1);
            chk("R2 mst_rdata", mst_rdata, VEC[k]);
            chk("R9 irq", irq, 1);
            chk("R9 slv_full idle", slv_full, 0);
            chk("R3 scl_hold", scl_hold, 0);
            send_bit(1'b0, 1'b0);
            strobe(2);
            chk("R4 flag cleared", mst_full, 0);
            chk("R4 rdata kept", mst_rdata, VEC[k]);
            chk("R9 irq low", irq, 0);
        end

        // R5 / R6 stall and release
        send_byte(8'hA1);
        send_bit(1'b0, 1'b0);
        send_byte(8'h3C);
        chk("R5 scl_hold", scl_hold, 1);
        chk("R5 rdata kept", mst_rdata, 8'hA1);
        chk("R5 flag", mst_full, 1);
        strobe(2);
        chk("R6 scl_hold released", scl_hold, 0);
        chk("R6 held byte loaded", mst_rdata, 8'h3C);
        chk("R6 flag set", mst_full, 1);
        send_bit(1'b0, 1'b0);
        strobe(2);
        chk("R4 clear after reload", mst_full, 0);

        // R7 clear in the completion tick
        send_byte(8'h11);
        send_bit(1'b0, 1'b0);
        for (int i = DW - 1; i >= 1; i--) send_bit(8'hE7 >> i, 1'b0);
        send_bit(1'b1, 1'b1);
        chk("R7 new byte", mst_rdata, 8'hE7);
        chk("R7 flag", mst_full, 1);
        chk("R7 no hold", scl_hold, 0);
        send_bit(1'b0, 1'b0);

        // R1 tick low
        tick = 1'b0;
        send_bit(1'b1, 1'b0);
        strobe(2);
        chk("R1 flag kept", mst_full, 1);
        chk("R1 rdata kept", mst_rdata, 8'hE7);
        tick = 1'b1;
        strobe(2);
        chk("R4 flag cleared", mst_full, 0);
        chk("R4 rdata kept", mst_rdata, 8'hE7);

        // R8 stop keeps flag, idle ignores edges, start restarts
        send_byte(8'h5A);
        send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0);
        strobe(1);
        chk("R8 flag kept on stop", mst_full, 1);
        chk("R8 rdata kept on stop", mst_rdata, 8'h5A);
        strobe(2);
        send_byte(8'hFF);
        chk("R8 idle ignores edges", mst_full, 0);
        strobe(0);
        send_byte(8'h69);
        chk("R8 count cleared", mst_rdata, 8'h69);
        send_bit(1'b0, 1'b0);

        // R8 stop during stall
        send_byte(8'hC3);
        chk("R5 stall", scl_hold, 1);
        strobe(1);
        chk("R8 stop releases", scl_hold, 0);
        chk("R8 flag kept", mst_full, 1);
        chk("R8 rdata kept", mst_rdata, 8'h69);
        strobe(2);
        chk("R8 parked byte dropped", mst_full, 0);
        chk("R8 parked byte not loaded", mst_rdata, 8'h69);

        // R8 START discards a partial byte
        strobe(0);
        send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0);
        strobe(0);
        send_byte(8'h24);
        chk("R8 restart byte", mst_rdata, 8'h24);
        send_bit(1'b0, 1'b0);
        strobe(2);
        strobe(1);

        // R9 independent paths
        strobe(3);
        send_byte(8'h96);
        chk("R9 slv_full", slv_full, 1);
        chk("R9 slv_rdata", slv_rdata, 8'h96);
        chk("R9 mst_full idle", mst_full, 0);
        chk("R9 irq slave", irq, 1);
        send_bit(1'b0, 1'b0);
        strobe(0);
        send_byte(8'h4B);
        chk("R9 mst loads", mst_rdata, 8'h4B);
        chk("R9 mst_full", mst_full, 1);
        chk("R9 slave stalls bus", scl_hold, 1);
        chk("R9 slv_rdata kept", slv_rdata, 8'h96);
        strobe(5);
        chk("R9 slave release", scl_hold, 0);
        chk("R9 slave reload", slv_rdata, 8'h4B);
        strobe(2);
        chk("R9 irq from slave", irq, 1);
        chk("R9 mst cleared", mst_full, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule